// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block compares two 32-bit single-precision floating-point values and reports the ordering through two registered flags: a zero flag (operands equal) and a negative flag (first operand below the second). Operands live in a four-entry register file with one write port. A compare is started by presenting a two-word instruction whose fields pick the two source entries.

Before the compare, each operand is put into a canonical form. Zero-exponent encodings (signed zeros and denormals) collapse to positive zero. NaNs turn into infinity with their sign kept. The two canonical words are then ordered as sign-magnitude integers. That is valid because the biased exponent sits above the fraction, so a larger field pattern means a larger value within one sign.

Only the zero and negative flags exist here. They change only on a recognised compare instruction and keep their value otherwise.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When the canonical values of operand A and operand B are equal, a compare sets zero_flag=1 and neg_flag=0 (for example, a value compared with itself).
- R2: When A is greater than B, a compare sets zero_flag=0 and neg_flag=0 (for example, 5.0 = 0x40A00000 against -2.0 = 0xC0000000).
- R3: When A is less than B, a compare sets zero_flag=0 and neg_flag=1. Ordering rules: with differing signs the positive value is greater; with both signs positive the larger magnitude is greater; with both negative the smaller magnitude is greater.
- R4: Negative zero (0x80000000) is treated as positive zero, so +0 and -0 compare equal.
- R5: Any operand whose exponent field (bits 30:23) is zero is treated as positive zero, whatever its sign or fraction.
- R6: Any operand whose exponent field is all ones with a nonzero fraction (bits 22:0) is treated as infinity of the same sign: 0xFFC00000 equals 0xFF800000, and 0x7FC00001 equals 0x7F800000.
- R7: instr_lo bits 1:0 select the register for A and bits 3:2 select the register for B. A write (wr_en, wr_addr, wr_data) takes effect at the clock edge, so a compare in the same cycle still sees the old contents.
- R8: A compare is recognised only when instr_valid=1, instr_hi=0x7D00 and instr_lo bits 15:4 are all zero. In every other cycle both flags keep their value.
- R9: The flags show the result of a recognised compare right after the same clock edge at which it was presented. There is no added latency.
- R10: A synchronous active-high reset clears both flags to 0.
- R11: zero_flag and neg_flag are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register file write enable |
| wr_addr | input | 2 | Register file write index |
| wr_data | input | 32 | Register file write data |
| instr_valid | input | 1 | Instruction words present this cycle |
| instr_hi | input | 16 | Upper instruction word (opcode) |
| instr_lo | input | 16 | Lower instruction word (register selects, rest zero) |
| zero_flag | output | 1 | Set when A equals B |
| neg_flag | output | 1 | Set when A is below B |

## Verification
Directed compares of -2.0 and 5.0, in both orders and against themselves, separate the three outcomes. Pairs of same-sign values separate a correct magnitude rule from an inverted one for negative operands. Signed zeros, denormals of both signs, and NaNs set against infinities and finite values show whether each remap happens and whether the NaN sign is kept. Near-miss instruction words, writes without a compare, and a write to an entry being compared in the same cycle check decode, flag holding and read-before-write. A long random run mixes these special encodings with ordinary values.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef struct packed {
    logic zf;
    logic nf;
  } cmp_flags_t;

  localparam cmp_flags_t FLAGS_EQ = '{zf: 1'b1, nf: 1'b0};
  localparam cmp_flags_t FLAGS_GT = '{zf: 1'b0, nf: 1'b0};
  localparam cmp_flags_t FLAGS_LT = '{zf: 1'b0, nf: 1'b1};
endpackage

// File: rtl/fcmp_regfile.sv
module fcmp_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_a,
  output logic [WIDTH-1:0] rdata_b
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fcmp_decode.sv
module fcmp_decode #(
  parameter int          IW     = 16,
  parameter int          SEL_W  = 2,
  parameter logic [15:0] OPC_HI = 16'h7D00
) (
  input  logic             valid,
  input  logic [IW-1:0]    word_hi,
  input  logic [IW-1:0]    word_lo,
  output logic             hit,
  output logic [SEL_W-1:0] sel_a,
  output logic [SEL_W-1:0] sel_b
);
  localparam int RSV_LSB = 2 * SEL_W;

  assign hit   = valid && (word_hi == OPC_HI[IW-1:0]) && (word_lo[IW-1:RSV_LSB] == '0);
  assign sel_a = word_lo[SEL_W-1:0];
  assign sel_b = word_lo[RSV_LSB-1:SEL_W];
endmodule

// File: rtl/fcmp_canon.sv
module fcmp_canon #(
  parameter int WIDTH = 32,
  parameter int EXP_W = 8,
  localparam int FRAC_W = WIDTH - 1 - EXP_W
) (
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] canon
);
  logic              sgn;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;

  assign sgn  = raw[WIDTH-1];
  assign expo = raw[WIDTH-2 -: EXP_W];
  assign frac = raw[FRAC_W-1:0];

  always_comb begin
    if (expo == '0)
      canon = '0;
    else if ((expo == '1) && (frac != '0))
      canon = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else
      canon = raw;
  end
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
  import fcmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output cmp_flags_t       res
);
  logic mag_gt;
  logic a_gt;

  assign mag_gt = a[WIDTH-2:0] > b[WIDTH-2:0];

  always_comb begin
    if (a[WIDTH-1] != b[WIDTH-1])
      a_gt = ~a[WIDTH-1];
    else if (!a[WIDTH-1])
      a_gt = mag_gt;
    else
      a_gt = ~mag_gt;
    if (a == b)
      res = FLAGS_EQ;
    else if (a_gt)
      res = FLAGS_GT;
    else
      res = FLAGS_LT;
  end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
  import fcmp_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int EXP_W = 8,
  parameter int NREGS = 4,
  parameter int IW    = 16,
  localparam int SEL_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             instr_valid,
  input  logic [IW-1:0]    instr_hi,
  input  logic [IW-1:0]    instr_lo,
  output logic             zero_flag,
  output logic             neg_flag
);
  localparam int FRAC_W = WIDTH - 1 - EXP_W;

  logic             dec_hit;
  logic [SEL_W-1:0] sel_a, sel_b;
  logic [WIDTH-1:0] opnd [2];
  logic [WIDTH-1:0] canon [2];
  cmp_flags_t       nxt;

  fcmp_decode #(.IW(IW), .SEL_W(SEL_W)) u_dec (
    .valid(instr_valid), .word_hi(instr_hi), .word_lo(instr_lo),
    .hit(dec_hit), .sel_a(sel_a), .sel_b(sel_b)
  );

  fcmp_regfile #(.WIDTH(WIDTH), .DEPTH(NREGS)) u_rf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr_a(sel_a), .raddr_b(sel_b), .rdata_a(opnd[0]), .rdata_b(opnd[1])
  );

  for (genvar g = 0; g < 2; g++) begin : g_canon
    fcmp_canon #(.WIDTH(WIDTH), .EXP_W(EXP_W)) u_canon (
      .raw(opnd[g]), .canon(canon[g])
    );
  end

  fcmp_order #(.WIDTH(WIDTH)) u_ord (.a(canon[0]), .b(canon[1]), .res(nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_flag <= 1'b0;
      neg_flag  <= 1'b0;
    end else if (dec_hit) begin
      zero_flag <= nxt.zf;
      neg_flag  <= nxt.nf;
    end
  end

  // Assertions: operand-level facts checked against the registered flags
  logic [EXP_W-1:0] ea, eb;
  logic             a_nan;
  assign ea    = opnd[0][WIDTH-2 -: EXP_W];
  assign eb    = opnd[1][WIDTH-2 -: EXP_W];
  assign a_nan = (ea == '1) && (opnd[0][FRAC_W-1:0] != '0);

  a_r1_self_equal: assert property (@(posedge clk) disable iff (rst)
    (dec_hit && opnd[0] == opnd[1]) |=> (zero_flag && !neg_flag));

  a_r2_pos_beats_neg: assert property (@(posedge clk) disable iff (rst)
    (dec_hit && ea != '0 && eb != '0 && !opnd[0][WIDTH-1] && opnd[1][WIDTH-1])
      |=> (!zero_flag && !neg_flag));

  a_r5_zero_exps_equal: assert property (@(posedge clk) disable iff (rst)
    (dec_hit && ea == '0 && eb == '0) |=> (zero_flag && !neg_flag));

  a_r6_nan_is_inf: assert property (@(posedge clk) disable iff (rst)
    (dec_hit && a_nan && opnd[1] == {opnd[0][WIDTH-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}})
      |=> zero_flag);

  a_r8_hold_flags: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |=> ($stable(zero_flag) && $stable(neg_flag)));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!zero_flag && !neg_flag));

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(zero_flag && neg_flag));
endmodule

// File: tb/fcmp_flag_unit_tb.sv
module fcmp_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr_hi = '0;
  logic [15:0] instr_lo = '0;
  logic        zero_flag, neg_flag;

  int          n_run = 0;
  int          n_fail = 0;
  logic [31:0] mregs [4];
  logic        ezf = 1'b0, enf = 1'b0;

  always #5 clk = ~clk;

  fcmp_flag_unit u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .instr_valid(instr_valid), .instr_hi(instr_hi), .instr_lo(instr_lo),
    .zero_flag(zero_flag), .neg_flag(neg_flag)
  );

  function automatic logic [31:0] canon(input logic [31:0] v);
    if (v[30:23] == 8'h00) return 32'h0;
    if (v[30:23] == 8'hFF && v[22:0] != 0) return {v[31], 8'hFF, 23'h0};
    return v;
  endfunction

  function automatic logic [1:0] ref_cmp(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] ca, cb;
    logic gt;
    ca = canon(a);
    cb = canon(b);
    if (ca == cb) return 2'b10;
    if (ca[31] != cb[31]) gt = !ca[31];
    else if (!ca[31]) gt = ca[30:0] > cb[30:0];
    else gt = ca[30:0] < cb[30:0];
    return gt ? 2'b00 : 2'b01;
  endfunction

  task automatic check(input string tag);
    n_run++;
    if (zero_flag !== ezf || neg_flag !== enf) begin
      n_fail++;
      $display("FAIL %s: zf/nf actual %b%b expected %b%b", tag, zero_flag, neg_flag, ezf, enf);
    end
  endtask

  // One cycle: drive at negedge, model the edge, check at the next negedge
  task automatic cyc(input logic wv, input logic [1:0] wa, input logic [31:0] wd,
                     input logic iv, input logic [15:0] hi, input logic [15:0] lo,
                     input string tag);
    wr_en = wv; wr_addr = wa; wr_data = wd;
    instr_valid = iv; instr_hi = hi; instr_lo = lo;
    @(posedge clk);
    if (iv && hi == 16'h7D00 && lo[15:4] == 12'h0)
      {ezf, enf} = ref_cmp(mregs[lo[1:0]], mregs[lo[3:2]]);
    if (wv) mregs[wa] = wd;
    @(negedge clk);
    check(tag);
    wr_en = 1'b0;
    instr_valid = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 16'h0, 16'h0, "R8 write without compare holds flags");
  endtask

  task automatic cmp(input logic [1:0] ra, input logic [1:0] rb, input string tag);
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 16'h7D00, {12'h0, rb, ra}, tag);
  endtask

  task automatic pair(input logic [31:0] a, input logic [31:0] b, input string tag);
    wr(2'd2, a);
    wr(2'd3, b);
    cmp(2'd2, 2'd3, tag);
  endtask

  function automatic logic [31:0] rnd_val();
    logic [31:0] r;
    r = $urandom;
    case ($urandom_range(0, 7))
      0: return {r[31], 8'h00, r[22:0]};
      1: return {r[31], 8'hFF, r[22:0]};
      2: return {r[31], 31'h0};
      3: return {r[31], 8'hFF, 23'h0};
      4: return {r[31], 8'h3F, r[22:20], 20'h0};
      default: return r;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mregs[i] = 32'h0;
    // Registers start unknown in the DUT: load every entry while still in reset
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      wr_en = 1'b1; wr_addr = 2'(i); wr_data = 32'h0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    ezf = 1'b0; enf = 1'b0;
    check("R10 reset clears flags");

    wr(2'd1, 32'hC0000000);
    wr(2'd0, 32'h40A00000);
    cmp(2'd1, 2'd0, "R3 -2.0 vs 5.0 is less");
    cmp(2'd0, 2'd1, "R2 5.0 vs -2.0 is greater");
    cmp(2'd0, 2'd0, "R1 value vs itself equal");
    cmp(2'd1, 2'd1, "R1 R9 negative vs itself equal");

    pair(32'h3F800000, 32'h40000000, "R3 both positive smaller magnitude less");
    pair(32'hBF800000, 32'hC0000000, "R2 both negative smaller magnitude greater");
    pair(32'hC0000000, 32'hBF800000, "R3 both negative larger magnitude less");
    pair(32'h80000000, 32'h00000000, "R4 -0 equals +0");
    pair(32'h80000000, 32'h3F800000, "R4 -0 less than 1.0");
    pair(32'h80000001, 32'h00000000, "R5 negative denormal equals zero");
    pair(32'h007FFFFF, 32'h80000000, "R5 positive denormal equals -0");
    pair(32'h807FFFFF, 32'h00800000, "R5 denormal below smallest normal");
    pair(32'hBF800000, 32'h80400000, "R5 -1.0 below negative denormal");
    pair(32'hFFC00000, 32'hFF800000, "R6 negative NaN equals -inf");
    pair(32'h7FC00001, 32'h7F800000, "R6 positive NaN equals +inf");
    pair(32'hFFC00000, 32'hC0000000, "R6 negative NaN below -2.0");
    pair(32'h7F800001, 32'hFF800001, "R6 positive NaN above negative NaN");

    // R8 decode: near misses must leave the flags unchanged
    pair(32'h3F800000, 32'h40000000, "R3 setup before decode checks");
    cyc(1'b0, 2'd0, 32'h0, 1'b0, 16'h7D00, 16'h0003, "R8 instr_valid low ignored");
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 16'h7D01, 16'h0003, "R8 wrong opcode ignored");
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 16'h7D00, 16'h0013, "R8 reserved bit 4 ignored");
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 16'h7D00, 16'h8003, "R8 reserved bit 15 ignored");
    cyc(1'b0, 2'd0, 32'h0, 1'b1, 16'h7D00, 16'h000E, "R7 A=reg2 B=reg3 field order");

    // R7 same-cycle write sees old contents
    wr(2'd2, 32'h40000000);
    wr(2'd3, 32'h40000000);
    cyc(1'b1, 2'd3, 32'h41000000, 1'b1, 16'h7D00, 16'h000E, "R7 write same cycle reads old value");
    cmp(2'd2, 2'd3, "R7 write visible on next compare");

    for (int k = 0; k < 400; k++) begin
      logic wv;
      logic iv;
      logic [15:0] lo;
      wv = ($urandom_range(0, 1) == 1);
      iv = ($urandom_range(0, 3) != 0);
      lo = {($urandom_range(0, 7) == 0) ? 12'h010 : 12'h000, 4'($urandom)};
      cyc(wv, 2'($urandom), rnd_val(), iv, ($urandom_range(0, 9) == 0) ? 16'h7C00 : 16'h7D00,
          lo, "R1 R2 R3 R11 random compare");
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    ezf = 1'b0; enf = 1'b0;
    check("R10 reset clears flags again");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule